// File: doc/BRIEF.md
# Output Commit Gating Buffer

This block sits on the write path from a core that can roll back to a checkpoint toward a device that cannot be rolled back. Every outgoing write request carries the number of the checkpoint epoch in which it was issued. Ordinary requests wait in an ordered queue until the error checker reports that their epoch has been fully checked and found clean. Only then are they handed to the device. An output that has reached the device cannot be taken back. For that reason a rollback throws away every ordinary request still waiting and leaves alone the one already on the device port.

Some requests are flagged as safe to repeat, such as a write of a value to a fixed location. These skip the check and go out through a short side queue of their own. A rollback leaves that side queue intact, because replaying such a write after recovery does no harm. The checker reports through a single-cycle pulse with an epoch number. A rollback is a single-cycle pulse. Epochs are plain unsigned numbers and are expected to increase without wrapping.

Top module: `commit_gate`

## Requirements
- R1: After reset `dev_valid` is 0 and `req_ready` is 1.
- R2: An ordinary request (`req_idem`=0) with epoch E reaches the device port only after a check pulse with `chk_epoch` ≥ E has been accepted. No ordinary request leaves before the first accepted check pulse.
- R3: Ordinary requests reach the device in the order they were accepted, none is duplicated, and a request that has not been discarded is eventually delivered once its epoch is validated.
- R4: A repeat-safe request (`req_idem`=1) is delivered without any check pulse. When the device register is free, a waiting repeat-safe request is loaded ahead of any ordinary request.
- R5: A `rollback` pulse discards every ordinary request that is not yet in the device register. This includes an ordinary request accepted in the same cycle. A request already in the device register stays there until it is taken.
- R6: A `rollback` pulse does not discard any repeat-safe request.
- R7: When the queue for the class selected by `req_idem` is full, `req_ready` is 0 and no accepted request is lost.
- R8: A check pulse that arrives in the same cycle as `rollback` has no effect on the validated epoch.
- R9: The validated epoch only rises. A check pulse carrying a lower epoch than the current one leaves it unchanged.
- R10: While `dev_valid` is 1 and `dev_ready` is 0, `dev_valid`, `dev_data` and `dev_idem` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted this cycle; depends on `req_idem` |
| req_data | input | DATA_W | Request payload |
| req_epoch | input | EPOCH_W | Checkpoint epoch of the request |
| req_idem | input | 1 | 1 = request is safe to repeat |
| chk_pass | input | 1 | Pulse: epochs up to `chk_epoch` are checked clean |
| chk_epoch | input | EPOCH_W | Highest clean epoch in that pulse |
| rollback | input | 1 | Pulse: recovery to checkpoint, discard waiting writes |
| dev_valid | output | 1 | Request presented to device (registered) |
| dev_ready | input | 1 | Device takes the presented request |
| dev_data | output | DATA_W | Payload to device (registered) |
| dev_idem | output | 1 | Presented request is the repeat-safe kind |

## Verification
The bench builds the block with DATA_W=16, EPOCH_W=6, a gated queue of depth 4 and a side queue of depth 2. With depths that small, both queues fill within a few cycles. That brings the full-queue back-pressure of both classes, and rollbacks that hit a full queue, within easy reach of the random phase. Six epoch bits leave room for dozens of increasing epochs without wrap. Each payload carries its own epoch in its top bits, so every delivered ordinary request can be compared against the validated epoch known to the bench.

// File: rtl/commit_gate_pkg.sv
package commit_gate_pkg;
  // which queue feeds the device register in a cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IDEM = 2'd1,
    SRC_GATE = 2'd2
  } src_sel_e;
endpackage

// File: rtl/cg_fifo.sv
module cg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  // R7: writer must respect back-pressure
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |-> !full);

  // R3: reader never pops an empty queue
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/cg_epoch_gate.sv
module cg_epoch_gate #(
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pass,
  input  logic [EW-1:0] pass_epoch,
  input  logic          rollback,
  input  logic [EW-1:0] head_epoch,
  output logic          head_ok
);
  logic          seen;
  logic [EW-1:0] last_ep;
  logic          take;

  // a pulse coinciding with rollback is dropped; lower epochs never lower the mark
  assign take    = pass && !rollback && (!seen || pass_epoch > last_ep);
  assign head_ok = seen && (head_epoch <= last_ep);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_ep <= '0;
    end else if (take) begin
      seen    <= 1'b1;
      last_ep <= pass_epoch;
    end
  end

  // R8: check pulse together with rollback leaves the mark untouched
  assert_pass_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (pass && rollback) |=> ($stable(last_ep) && $stable(seen)));

  // R9: validated epoch never decreases
  assert_epoch_rises_R9: assert property (@(posedge clk) disable iff (rst)
    seen |=> (seen && last_ep >= $past(last_ep)));
endmodule

// File: rtl/commit_gate.sv
module commit_gate
  import commit_gate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int EPOCH_W    = 8,
  parameter int DEPTH      = 16,
  parameter int IDEM_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [EPOCH_W-1:0] req_epoch,
  input  logic               req_idem,
  input  logic               chk_pass,
  input  logic [EPOCH_W-1:0] chk_epoch,
  input  logic               rollback,
  output logic               dev_valid,
  input  logic               dev_ready,
  output logic [DATA_W-1:0]  dev_data,
  output logic               dev_idem
);
  localparam int GW = DATA_W + EPOCH_W;

  logic              gq_full, gq_empty, gq_wr, gq_rd;
  logic [GW-1:0]     gq_out;
  logic              iq_full, iq_empty, iq_wr, iq_rd;
  logic [DATA_W-1:0] iq_out;
  logic              head_ok, load_ok, accept;
  src_sel_e          src;

  assign req_ready = req_idem ? !iq_full : !gq_full;
  assign accept    = req_valid && req_ready;
  assign gq_wr     = accept && !req_idem;
  assign iq_wr     = accept && req_idem;

  // ordered queue of writes waiting for validation
  cg_fifo #(.W(GW), .DEPTH(DEPTH)) u_gate_q (
    .clk(clk), .rst(rst), .flush(rollback),
    .wr_en(gq_wr), .wr_data({req_epoch, req_data}), .full(gq_full),
    .rd_en(gq_rd), .rd_data(gq_out), .empty(gq_empty)
  );

  // side queue for repeat-safe writes, untouched by rollback
  cg_fifo #(.W(DATA_W), .DEPTH(IDEM_DEPTH)) u_idem_q (
    .clk(clk), .rst(rst), .flush(1'b0),
    .wr_en(iq_wr), .wr_data(req_data), .full(iq_full),
    .rd_en(iq_rd), .rd_data(iq_out), .empty(iq_empty)
  );

  cg_epoch_gate #(.EW(EPOCH_W)) u_epoch (
    .clk(clk), .rst(rst),
    .pass(chk_pass), .pass_epoch(chk_epoch), .rollback(rollback),
    .head_epoch(gq_out[GW-1:DATA_W]), .head_ok(head_ok)
  );

  assign load_ok = !dev_valid || dev_ready;

  always_comb begin
    src = SRC_NONE;
    if (load_ok) begin
      if (!iq_empty)                             src = SRC_IDEM;
      else if (!gq_empty && head_ok && !rollback) src = SRC_GATE;
    end
  end

  assign iq_rd = (src == SRC_IDEM);
  assign gq_rd = (src == SRC_GATE);

  // registered device port: loading here is the point of no return
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_valid <= 1'b0;
      dev_data  <= '0;
      dev_idem  <= 1'b0;
    end else if (load_ok) begin
      dev_valid <= (src != SRC_NONE);
      if (src == SRC_IDEM) begin
        dev_data <= iq_out;
        dev_idem <= 1'b1;
      end else if (src == SRC_GATE) begin
        dev_data <= gq_out[DATA_W-1:0];
        dev_idem <= 1'b0;
      end
    end
  end

  // R5: nothing waiting in the gated queue survives a rollback
  assert_rollback_flush_R5: assert property (@(posedge clk) disable iff (rst)
    rollback |=> gq_empty);

  // R4: a waiting repeat-safe write wins the free device register
  assert_idem_first_R4: assert property (@(posedge clk) disable iff (rst)
    (!iq_empty && load_ok) |=> (dev_valid && dev_idem));

  // R10: presented request holds while the device stalls
  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data) && $stable(dev_idem)));
endmodule

// File: tb/commit_gate_bench.sv
module commit_gate_bench;
  localparam int DW = 16;
  localparam int EW = 6;
  localparam int GD = 4;
  localparam int ID = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 0, req_idem = 0, chk_pass = 0, rollback = 0, dev_ready = 0;
  logic [DW-1:0] req_data = '0;
  logic [EW-1:0] req_epoch = '0, chk_epoch = '0;
  logic          req_ready, dev_valid, dev_idem;
  logic [DW-1:0] dev_data;

  always #5 clk = ~clk;

  commit_gate #(.DATA_W(DW), .EPOCH_W(EW), .DEPTH(GD), .IDEM_DEPTH(ID)) u_commit_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_epoch(req_epoch), .req_idem(req_idem),
    .chk_pass(chk_pass), .chk_epoch(chk_epoch), .rollback(rollback),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_data(dev_data), .dev_idem(dev_idem)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] gq_m[$];
  logic [DW-1:0] iq_m[$];
  bit            val_seen = 0;
  logic [EW-1:0] val_max = '0;
  logic [9:0]    serial = '0;
  int            idem_out = 0, gate_out = 0;
  bit            was_stalled = 0;
  logic [DW-1:0] stall_data;
  logic          stall_idem;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit epoch_ok(input logic [DW-1:0] d);
    return val_seen && (d[DW-1:DW-EW] <= val_max);
  endfunction

  // one clock of stimulus plus model update
  task automatic cyc(input bit rv, input bit ri, input logic [EW-1:0] ep,
                     input bit cp, input logic [EW-1:0] cep, input bit rb, input bit dr);
    bit hs;
    @(negedge clk);
    if (was_stalled)
      check(dev_valid && dev_data == stall_data && dev_idem == stall_idem,
            "R10 hold during stall", dev_data, stall_data);
    req_valid = rv; req_idem = ri; req_epoch = ep; req_data = {ep, serial};
    chk_pass = cp; chk_epoch = cep; rollback = rb; dev_ready = dr;
    #1;
    hs = dev_valid && dr;
    was_stalled = dev_valid && !dr;
    stall_data = dev_data; stall_idem = dev_idem;
    if (hs) begin
      if (dev_idem) begin
        idem_out++;
        check(iq_m.size() > 0 && dev_data == iq_m[0], "R4 repeat-safe output",
              dev_data, iq_m.size() > 0 ? iq_m[0] : 0);
        if (iq_m.size() > 0) void'(iq_m.pop_front());
      end else begin
        gate_out++;
        check(gq_m.size() > 0 && dev_data == gq_m[0], "R3 ordered output",
              dev_data, gq_m.size() > 0 ? gq_m[0] : 0);
        check(epoch_ok(dev_data), "R2 epoch validated before release",
              dev_data[DW-1:DW-EW], val_max);
        if (gq_m.size() > 0) void'(gq_m.pop_front());
      end
    end
    if (rb) begin
      if (dev_valid && !dev_idem && !hs && gq_m.size() > 0) begin
        logic [DW-1:0] keep;
        keep = gq_m[0];
        gq_m.delete();
        gq_m.push_back(keep);
      end else gq_m.delete();
    end
    if (cp && !rb && (!val_seen || cep > val_max)) begin
      val_seen = 1; val_max = cep;
    end
    if (rv && req_ready) begin
      if (ri) iq_m.push_back({ep, serial});
      else if (!rb) gq_m.push_back({ep, serial});
      serial++;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n, input bit dr);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, '0, 0, dr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, g0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(dev_valid == 0, "R1 reset dev_valid", dev_valid, 0);
    check(req_ready == 1, "R1 reset req_ready", req_ready, 1);

    // R2: nothing before validation, nor with a lower validated epoch
    for (int i = 0; i < 3; i++) cyc(1, 0, 6'd1, 0, '0, 0, 1);
    idle(8, 1);
    check(dev_valid == 0 && gate_out == 0, "R2 held before any check", gate_out, 0);
    cyc(0, 0, '0, 1, 6'd0, 0, 1);
    idle(6, 1);
    check(gate_out == 0, "R2 held with epoch 0 validated", gate_out, 0);
    cyc(0, 0, '0, 1, 6'd1, 0, 1);
    idle(10, 1);
    check(gate_out == 3 && gq_m.size() == 0, "R3 all three delivered", gate_out, 3);

    // R4 bypass, R5 rollback with R8 coincident check pulse
    g0 = gate_out;
    cyc(1, 0, 6'd3, 0, '0, 0, 1);
    cyc(1, 0, 6'd3, 0, '0, 0, 1);
    cyc(1, 1, 6'd3, 0, '0, 0, 1);
    cyc(1, 1, 6'd3, 0, '0, 0, 1);
    idle(6, 1);
    check(idem_out == 2, "R4 repeat-safe without check", idem_out, 2);
    check(gate_out == g0, "R2 gated ones still waiting", gate_out, g0);
    cyc(1, 0, 6'd3, 1, 6'd5, 1, 1);
    idle(6, 1);
    cyc(1, 0, 6'd4, 0, '0, 0, 1);
    idle(8, 1);
    check(gate_out == g0 && dev_valid == 0, "R8 check with rollback ignored", gate_out, g0);
    cyc(0, 0, '0, 1, 6'd4, 0, 1);
    idle(6, 1);
    check(gate_out == g0 + 1, "R5 only post-rollback request delivered", gate_out, g0 + 1);

    // R9: lower epoch pulse does not lower the mark
    g0 = gate_out;
    cyc(0, 0, '0, 1, 6'd2, 0, 1);
    cyc(1, 0, 6'd4, 0, '0, 0, 1);
    idle(6, 1);
    check(gate_out == g0 + 1, "R9 mark kept at 4", gate_out, g0 + 1);

    // R5 + R10: request in device register survives rollback
    g0 = gate_out;
    cyc(1, 0, 6'd5, 1, 6'd5, 0, 0);
    cyc(1, 0, 6'd6, 0, '0, 0, 0);
    idle(4, 0);
    check(dev_valid == 1, "R10 presented under stall", dev_valid, 1);
    cyc(0, 0, '0, 0, '0, 1, 0);
    idle(3, 0);
    idle(6, 1);
    check(gate_out == g0 + 1, "R5 released request kept, rest dropped", gate_out, g0 + 1);
    cyc(0, 0, '0, 1, 6'd6, 0, 1);
    idle(6, 1);
    check(gate_out == g0 + 1, "R5 discarded request never appears", gate_out, g0 + 1);

    // R7 full gated queue, R6 rollback keeps repeat-safe ones
    g0 = gate_out;
    n0 = idem_out;
    for (int i = 0; i < GD; i++) cyc(1, 0, 6'd10, 0, '0, 0, 1);
    @(negedge clk);
    req_valid = 0; req_idem = 0; #1;
    check(req_ready == 0, "R7 ready low when gated queue full", req_ready, 0);
    req_idem = 1; #1;
    check(req_ready == 1, "R7 other class still ready", req_ready, 1);
    cyc(1, 0, 6'd10, 0, '0, 0, 1);
    cyc(0, 0, '0, 1, 6'd10, 0, 1);
    idle(10, 1);
    check(gate_out == g0 + GD, "R7 no request lost when full", gate_out, g0 + GD);
    for (int i = 0; i < 3; i++) cyc(1, 1, 6'd11, 0, '0, 0, 0);
    cyc(1, 0, 6'd11, 0, '0, 1, 0);
    idle(8, 1);
    check(idem_out == n0 + 3 && iq_m.size() == 0, "R6 repeat-safe kept over rollback",
          idem_out, n0 + 3);

    // random phase
    begin
      logic [EW-1:0] cur = 6'd12;
      for (int i = 0; i < 3000; i++) begin
        bit rv, ri, cp, rb, dr;
        logic [EW-1:0] ce;
        if (($urandom % 100) == 0 && cur < 6'd62) cur++;
        rv = ($urandom % 3) != 0;
        ri = ($urandom % 4) == 0;
        cp = ($urandom % 8) == 0;
        ce = cur - 6'(($urandom % 3));
        rb = ($urandom % 50) == 0;
        dr = ($urandom % 10) < 7;
        cyc(rv, ri, cur, cp, ce, rb, dr);
      end
      cyc(0, 0, '0, 1, cur, 0, 1);
      idle(40, 1);
    end
    check(gq_m.size() == 0, "R3 gated model drained", gq_m.size(), 0);
    check(iq_m.size() == 0, "R4 repeat-safe model drained", iq_m.size(), 0);
    check(dev_valid == 0, "R3 port idle at end", dev_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule